// File: doc/BRIEF.md
# Watchdog Frequency Self-Recovery Controller

This block guards a clock frequency change that software requests while the system is running. Software writes a new frequency code and raises a change request. If a four-bit timeout selection is nonzero at that moment, the new code is applied and a watchdog starts. Software that comes up cleanly at the new frequency writes the timeout selection back to zero. This stops the watchdog and keeps the new code.

If software fails to disarm the watchdog in time, the controller drives an active-low system reset pulse and raises an alarm flag. The first expiry after a request only resets the system. Each later expiry also reverts the active frequency code to a safe value. That value is either the strap code captured during reset or the software code that preceded the most recent one. The cycle repeats until software clears the timeout selection. Programming the synthesizer itself happens elsewhere; this block only produces the code that drives it.

The timeout length is the selection value times a parameterized unit of clock cycles. The reset pulse length is a separate parameter; its default corresponds to roughly 3 ms at the reference clock.

States: `ST_IDLE` (watchdog off), `ST_WATCH` (armed, no expiry yet), `ST_RECOVER` (at least one expiry seen). Transitions: ARM (`ST_IDLE`→`ST_WATCH` on a request with a nonzero selection), REARM (`ST_WATCH`/`ST_RECOVER`→`ST_WATCH` on a request), FIRST (`ST_WATCH`→`ST_RECOVER` on expiry), REPEAT (`ST_RECOVER`→`ST_RECOVER` on expiry), DISARM (any armed state→`ST_IDLE` when the selection is zero).

Top module: `wdfr_ctrl`

## Requirements
- R1: While and after `rst_n` is low, `freq_code` equals `strap_code`, `alarm` is 0 and `sys_rst_n` is 1.
- R2: A request (`chg_req`=1 at a clock edge) with `to_sel`=0 makes `freq_code` equal `sw_code` after that edge, and no reset pulse follows.
- R3: A request with `to_sel`≠0 makes `freq_code` equal `sw_code` after that edge. It starts a watchdog that expires at the edge N = `to_sel`×`UNIT_CYC` cycles after the request edge, and again every N cycles after that.
- R4: At each accepted expiry, `sys_rst_n` goes low starting right after the expiry edge, for exactly `PULSE_CYC` cycles, and `alarm` becomes 1. On the first expiry after a request, `freq_code` does not change.
- R5: At the second and each later expiry with `fb_prev`=0, `freq_code` reverts to the strap code captured during reset.
- R6: At the second and each later expiry with `fb_prev`=1, `freq_code` reverts to the software code that was requested before the most recent request.
- R7: When `to_sel` is 0 at an edge, `alarm` is 0 after it, the watchdog stops, and `freq_code` keeps its value.
- R8: If `to_sel` is 0 at the same edge where the watchdog would expire, the disarm wins: no pulse, `alarm` stays 0 and `freq_code` is kept.
- R9: A request while the watchdog runs restarts it from that edge, and the next expiry counts as a first expiry, so the frequency is kept.
- R10: Changes of `strap_code` after reset is released do not change the fallback code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; strap code is captured while low |
| to_sel | input | 4 | Timeout selection; 0 disarms, nonzero arms with length `to_sel`×`UNIT_CYC` |
| chg_req | input | 1 | One-cycle frequency change request |
| strap_code | input | FREQ_W | Hardware strap frequency code |
| sw_code | input | FREQ_W | Software-requested frequency code, read with `chg_req` |
| fb_prev | input | 1 | Fallback choice: 0 strap code, 1 previous software code |
| freq_code | output | FREQ_W | Active frequency code |
| alarm | output | 1 | Set on any expiry, cleared when `to_sel` is 0 |
| sys_rst_n | output | 1 | Active-low system reset pulse |

## Verification
The watchdog expiry and the software disarm can land on the same clock edge. The expiry wants to fire a pulse, set the alarm and possibly revert the frequency; the disarm wants to clear the alarm and stop everything. The bench arms a timeout of N cycles and drops `to_sel` to zero at exactly the N-th edge after the request. It then judges that `sys_rst_n` never falls, `alarm` reads 0 and the requested frequency code survives. A request landing near an expiry, which restarts the count and must not revert the frequency, is provoked in the same manner.

// File: rtl/wdfr_pkg.sv
package wdfr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WATCH,
        ST_RECOVER
    } wd_state_e;
endpackage

// File: rtl/wdfr_timer.sv
// Watchdog down-counter: length is sel * UNIT_CYC cycles from the load edge.
module wdfr_timer #(
    parameter int UNIT_CYC = 16,
    parameter int SEL_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);
    localparam int MAX_CYC = ((1 << SEL_W) - 1) * UNIT_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len;

    assign len = CNT_W'(int'(sel) * UNIT_CYC - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = run && (cnt_q == '0);
endmodule

// File: rtl/wdfr_rst_pulse.sv
// Stretches a one-cycle fire strobe into an active-low pulse of PULSE_CYC cycles.
module wdfr_rst_pulse #(
    parameter int PULSE_CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse_n
);
    localparam int PW = $clog2(PULSE_CYC + 1);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= PW'(PULSE_CYC);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign pulse_n = (left_q == '0);
endmodule

// File: rtl/wdfr_freq_sel.sv
// Holds the active code, the strap snapshot and a two-deep software history.
module wdfr_freq_sel #(
    parameter int FREQ_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREQ_W-1:0] strap_code,
    input  logic              apply,
    input  logic [FREQ_W-1:0] sw_code,
    input  logic              revert,
    input  logic              use_prev,
    output logic [FREQ_W-1:0] freq_code
);
    logic [FREQ_W-1:0] strap_q, sw_cur_q, sw_prev_q, freq_q;
    logic [FREQ_W-1:0] fallback;

    assign fallback = use_prev ? sw_prev_q : strap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_q   <= strap_code;
            sw_cur_q  <= strap_code;
            sw_prev_q <= strap_code;
            freq_q    <= strap_code;
        end else if (apply) begin
            sw_prev_q <= sw_cur_q;
            sw_cur_q  <= sw_code;
            freq_q    <= sw_code;
        end else if (revert) begin
            freq_q    <= fallback;
        end
    end

    assign freq_code = freq_q;
endmodule

// File: rtl/wdfr_ctrl.sv
module wdfr_ctrl
    import wdfr_pkg::*;
#(
    parameter int FREQ_W    = 5,
    parameter int UNIT_CYC  = 10000000,
    parameter int PULSE_CYC = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        to_sel,
    input  logic              chg_req,
    input  logic [FREQ_W-1:0] strap_code,
    input  logic [FREQ_W-1:0] sw_code,
    input  logic              fb_prev,
    output logic [FREQ_W-1:0] freq_code,
    output logic              alarm,
    output logic              sys_rst_n
);
    wd_state_e state_q, state_d;

    logic disarm, arm_req, expire, accept_exp;
    logic tmr_load, fire, revert, running, alarm_q;

    assign disarm  = (to_sel == 4'd0);
    assign arm_req = chg_req && !disarm;
    assign running = (state_q != ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and per-cycle strobes; priority: disarm, request, expiry
    always_comb begin
        state_d    = state_q;
        accept_exp = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_req) state_d = ST_WATCH;          // ARM
            end
            ST_WATCH: begin
                if (disarm) state_d = ST_IDLE;            // DISARM
                else if (chg_req) state_d = ST_WATCH;     // REARM
                else if (expire) begin
                    state_d    = ST_RECOVER;              // FIRST
                    accept_exp = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (disarm) state_d = ST_IDLE;            // DISARM
                else if (chg_req) state_d = ST_WATCH;     // REARM
                else if (expire) begin
                    state_d    = ST_RECOVER;              // REPEAT
                    accept_exp = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        tmr_load = arm_req || accept_exp;
        fire     = accept_exp;
        revert   = accept_exp && (state_q == ST_RECOVER);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q <= 1'b0;
        end else if (disarm) begin
            alarm_q <= 1'b0;
        end else if (fire) begin
            alarm_q <= 1'b1;
        end
    end

    assign alarm = alarm_q;

    wdfr_timer #(.UNIT_CYC(UNIT_CYC), .SEL_W(4)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .run    (running),
        .sel    (to_sel),
        .expire (expire)
    );

    wdfr_rst_pulse #(.PULSE_CYC(PULSE_CYC)) pulse_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .pulse_n (sys_rst_n)
    );

    wdfr_freq_sel #(.FREQ_W(FREQ_W)) freq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_code (strap_code),
        .apply      (chg_req),
        .sw_code    (sw_code),
        .revert     (revert),
        .use_prev   (fb_prev),
        .freq_code  (freq_code)
    );
endmodule

// File: rtl/wdfr_ctrl_chk.sv
module wdfr_ctrl_chk #(
    parameter int FREQ_W    = 5,
    parameter int PULSE_CYC = 100000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        to_sel,
    input logic              chg_req,
    input logic [FREQ_W-1:0] sw_code,
    input logic [FREQ_W-1:0] freq_code,
    input logic              alarm,
    input logic              sys_rst_n
);
    localparam int LW = $clog2(PULSE_CYC + 2) + 1;

    logic [LW-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_run <= '0;
        else if (sys_rst_n) low_run <= '0;
        else low_run <= low_run + 1'b1;
    end

    assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= LW'(PULSE_CYC));

    assert_alarm_with_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> $fell(sys_rst_n));

    assert_disarm_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (to_sel == 4'd0) |=> !alarm);

    assert_apply_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chg_req |=> (freq_code == $past(sw_code)));

    assert_code_moves_only_on_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_req |=> ($stable(freq_code) || $fell(sys_rst_n)));
endmodule

bind wdfr_ctrl wdfr_ctrl_chk #(.FREQ_W(FREQ_W), .PULSE_CYC(PULSE_CYC)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .to_sel    (to_sel),
    .chg_req   (chg_req),
    .sw_code   (sw_code),
    .freq_code (freq_code),
    .alarm     (alarm),
    .sys_rst_n (sys_rst_n)
);

// File: tb/wdfr_ctrl_tb_top.sv
`timescale 1ns/1ps
module wdfr_ctrl_tb_top;
    localparam int FW = 5;
    localparam int UC = 20;
    localparam int PC = 5;
    localparam logic [FW-1:0] STRAP = 5'h0A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    to_sel = 4'd0;
    logic          chg_req = 1'b0;
    logic [FW-1:0] strap_code = STRAP;
    logic [FW-1:0] sw_code = '0;
    logic          fb_prev = 1'b0;
    logic [FW-1:0] freq_code;
    logic          alarm;
    logic          sys_rst_n;

    int n_run = 0;
    int n_fail = 0;
    int s = 0;

    always #2 clk = ~clk;

    wdfr_ctrl #(.FREQ_W(FW), .UNIT_CYC(UC), .PULSE_CYC(PC)) dut_i (
        .clk(clk), .rst_n(rst_n), .to_sel(to_sel), .chg_req(chg_req),
        .strap_code(strap_code), .sw_code(sw_code), .fb_prev(fb_prev),
        .freq_code(freq_code), .alarm(alarm), .sys_rst_n(sys_rst_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic go(input int m);
        while (s < m) begin
            @(negedge clk);
            s++;
        end
    endtask

    // Issue a one-cycle request sampled at the next edge; sample index advances by one
    task automatic req(input logic [FW-1:0] code);
        sw_code = code;
        chg_req = 1'b1;
        @(negedge clk);
        s++;
        chg_req = 1'b0;
    endtask

    task automatic start(input logic [3:0] sel, input logic [FW-1:0] code);
        to_sel = sel;
        s = -1;
        req(code);
    endtask

    task automatic quiet(input int len, input string tag);
        int lows = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            s++;
            if (!sys_rst_n) lows++;
        end
        chk(lows == 0, tag, lows, 0);
    endtask

    task automatic expect_fire(input int at, input logic [FW-1:0] fexp, input string tag);
        go(at - 1);
        chk(sys_rst_n == 1'b1, {tag, " pulse not early"}, sys_rst_n, 1);
        go(at);
        chk(sys_rst_n == 1'b0 && alarm == 1'b1, {tag, " R4 pulse+alarm"}, {sys_rst_n, alarm}, 2'b01);
        chk(freq_code == fexp, {tag, " freq at expiry"}, freq_code, fexp);
        go(at + PC - 1);
        chk(sys_rst_n == 1'b0, {tag, " R4 pulse held"}, sys_rst_n, 0);
        go(at + PC);
        chk(sys_rst_n == 1'b1, {tag, " R4 pulse ends"}, sys_rst_n, 1);
    endtask

    task automatic disarm_now(input logic [FW-1:0] fexp, input string tag);
        to_sel = 4'd0;
        @(negedge clk);
        s++;
        chk(alarm == 1'b0, {tag, " R7 alarm cleared"}, alarm, 0);
        chk(freq_code == fexp, {tag, " R7 freq kept"}, freq_code, fexp);
        repeat (PC + 1) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(freq_code == STRAP && alarm == 0 && sys_rst_n == 1, "R1 during reset",
            {freq_code, alarm, sys_rst_n}, {STRAP, 2'b01});
        rst_n = 1'b1;
        @(negedge clk);
        chk(freq_code == STRAP && alarm == 0 && sys_rst_n == 1, "R1 after reset",
            {freq_code, alarm, sys_rst_n}, {STRAP, 2'b01});
        strap_code = 5'h1F;  // R10: later strap changes must be ignored
    endtask

    task automatic t_unarmed();
        start(4'd0, 5'h11);
        chk(freq_code == 5'h11, "R2 unarmed apply", freq_code, 5'h11);
        quiet(3 * UC, "R2 no pulse when unarmed");
        chk(freq_code == 5'h11, "R2 freq kept", freq_code, 5'h11);
    endtask

    task automatic t_strap_fallback();
        start(4'd1, 5'h12);
        chk(freq_code == 5'h12, "R3 armed apply", freq_code, 5'h12);
        expect_fire(UC, 5'h12, "R3 first expiry");
        expect_fire(2 * UC, STRAP, "R5 R10 second expiry strap");
        expect_fire(3 * UC, STRAP, "R5 third expiry");
        disarm_now(STRAP, "R7 after recovery");
        quiet(3 * UC, "R7 timer stopped");
    endtask

    task automatic t_early_disarm();
        start(4'd2, 5'h13);
        go(10);
        disarm_now(5'h13, "R7 early disarm");
        quiet(3 * UC, "R7 no pulse after early disarm");
        chk(freq_code == 5'h13, "R7 freq after early disarm", freq_code, 5'h13);
    endtask

    task automatic t_prev_fallback();
        fb_prev = 1'b1;
        start(4'd1, 5'h14);
        expect_fire(UC, 5'h14, "R6 first expiry");
        expect_fire(2 * UC, 5'h13, "R6 previous software code");
        disarm_now(5'h13, "R6 end");
        fb_prev = 1'b0;
    endtask

    task automatic t_race();
        start(4'd1, 5'h15);
        go(UC - 1);
        to_sel = 4'd0;  // sampled at the expiry edge
        go(UC);
        chk(sys_rst_n == 1'b1 && alarm == 1'b0, "R8 disarm beats expiry",
            {sys_rst_n, alarm}, 2'b10);
        chk(freq_code == 5'h15, "R8 freq kept", freq_code, 5'h15);
        quiet(3 * UC, "R8 no late pulse");
    endtask

    task automatic t_rearm();
        start(4'd1, 5'h16);
        go(14);
        req(5'h17);  // sampled at edge 15, next expiry at 35
        quiet(UC - 1, "R9 restart suppresses edge 20");
        expect_fire(35, 5'h17, "R9 rearm in watch");
        go(44);
        req(5'h18);  // from recover state, next expiry at 65
        expect_fire(65, 5'h18, "R9 rearm in recover first");
        expect_fire(85, STRAP, "R9 R10 later revert to captured strap");
        disarm_now(STRAP, "R9 end");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_unarmed();
                t_strap_fallback();
                t_early_disarm();
                t_prev_fallback();
                t_race();
                t_rearm();
            end
            begin
                repeat (100000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: run hung");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule